// File: doc/BRIEF.md
# Override-Multiplexed GPIO Port Slice

This block is a slice of a general-purpose I/O port with `NPINS` pins. Software-side registers give every pin a direction bit, a port bit and a shared global pull-up disable. On-chip peripherals can take over each pin through four pairs of enable and value signals: pull-up, direction, output value and digital-input enable. Whenever an enable is high, its value replaces whatever the registers would have produced for that control. Examples are a test-access port claiming its pins, a serial receiver forcing its pin to input, a transmitter or an external-memory strobe unit forcing a pin to output, a timer compare unit supplying the output level, and an oscillator that disconnects its pins.

The pad side gets an output value, an output enable and a pull-up enable. The pad input is resynchronised through two flops. It is then gated to 0 whenever the effective digital-input enable is low.

Top module: `gpio_override_port`

## Requirements
- R1: `pad_oe` equals `ovr_dir_val` when `ovr_dir_en` is 1 and `dir_reg` otherwise, per pin (1 = drive).
- R2: `pad_out` equals `ovr_out_val` when `ovr_out_en` is 1 and `port_reg` otherwise. An output override does not change `pad_oe`, so a compare output only reaches the pad when the effective direction is 1.
- R3: When `ovr_pu_en` is 1, `pad_pu` equals `ovr_pu_val`, regardless of the registers and of `pud_global`.
- R4: Without a pull-up override, `pad_pu` is 1 only if the effective direction (after R1) is 0, `port_reg` is 1 and `pud_global` is 0. This means a pin forced to input by a direction override gets its pull-up from its port bit.
- R5: Without a pull-up override, `pud_global` = 1 forces `pad_pu` to 0 on every pin.
- R6: The effective digital-input enable is `ovr_die_val` when `ovr_die_en` is 1, and 1 otherwise. While it is 0, `din_sync` is 0 in the same cycle.
- R7: With the input enabled, `din_sync` shows the value `pad_in` had at the rising edge two clock edges earlier. A change is therefore invisible after one edge and visible after the second.
- R8: While `rst_n` is 0 (asynchronous, active low), both synchroniser stages clear and `din_sync` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the input synchroniser |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_reg | input | NPINS | Register direction bits, 1 = output |
| port_reg | input | NPINS | Register port bits: output level or pull-up request |
| pud_global | input | 1 | Global pull-up disable |
| ovr_pu_en | input | NPINS | Pull-up override enable |
| ovr_pu_val | input | NPINS | Pull-up override value |
| ovr_dir_en | input | NPINS | Direction override enable |
| ovr_dir_val | input | NPINS | Direction override value |
| ovr_out_en | input | NPINS | Output value override enable |
| ovr_out_val | input | NPINS | Output value override value |
| ovr_die_en | input | NPINS | Digital-input enable override enable |
| ovr_die_val | input | NPINS | Digital-input enable override value |
| pad_in | input | NPINS | Raw level from the pads |
| pad_out | output | NPINS | Level driven to the pads |
| pad_oe | output | NPINS | Pad output enable |
| pad_pu | output | NPINS | Pad pull-up enable |
| din_sync | output | NPINS | Synchronised, gated digital input |

## Verification
The output value, output enable and pull-up are purely combinational. The bench checks them one time unit after it drives new controls, away from any clock edge. The input gating of R6 is also combinational and is checked the same way. `din_sync` is due two rising edges after `pad_in` changes. The bench drives the pad at a falling edge, confirms the old value after the first rising edge, and confirms the new value after the second. Reset values are sampled while reset is held and again after release, before any pad activity.

// File: rtl/gpio_override_port.sv
module gpio_override_port #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] dir_reg,
  input  logic [NPINS-1:0] port_reg,
  input  logic             pud_global,
  input  logic [NPINS-1:0] ovr_pu_en,
  input  logic [NPINS-1:0] ovr_pu_val,
  input  logic [NPINS-1:0] ovr_dir_en,
  input  logic [NPINS-1:0] ovr_dir_val,
  input  logic [NPINS-1:0] ovr_out_en,
  input  logic [NPINS-1:0] ovr_out_val,
  input  logic [NPINS-1:0] ovr_die_en,
  input  logic [NPINS-1:0] ovr_die_val,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] din_sync
);

  logic [NPINS-1:0] dir_eff, die_eff, pu_reg_side, meta_q, sync_q;

  assign dir_eff     = (ovr_dir_en & ovr_dir_val) | (~ovr_dir_en & dir_reg);
  assign die_eff     = (ovr_die_en & ovr_die_val) | ~ovr_die_en;
  assign pu_reg_side = ~dir_eff & port_reg & {NPINS{~pud_global}};

  assign pad_oe  = dir_eff;
  assign pad_out = (ovr_out_en & ovr_out_val) | (~ovr_out_en & port_reg);
  assign pad_pu  = (ovr_pu_en & ovr_pu_val) | (~ovr_pu_en & pu_reg_side);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  assign din_sync = sync_q & die_eff;

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    p_oe_from_reg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr_dir_en[i] |-> pad_oe[i] == dir_reg[i]);
    p_out_from_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr_out_en[i] |-> pad_out[i] == port_reg[i]);
    p_no_pu_when_driving_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_pu_en[i] && pad_oe[i]) |-> !pad_pu[i]);
    p_global_pud_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_pu_en[i] && pud_global) |-> !pad_pu[i]);
    p_input_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_die_en[i] && !ovr_die_val[i]) |-> !din_sync[i]);
    p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && (!ovr_die_en[i] || ovr_die_val[i]))
        |-> din_sync[i] == $past(pad_in[i], 2));
  end

endmodule

// File: tb/tb_gpio_override_port.sv
module tb_gpio_override_port;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] dir_reg, port_reg, ovr_pu_en, ovr_pu_val, ovr_dir_en, ovr_dir_val;
  logic [N-1:0] ovr_out_en, ovr_out_val, ovr_die_en, ovr_die_val, pad_in;
  logic pud_global;
  logic [N-1:0] pad_out, pad_oe, pad_pu, din_sync;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  gpio_override_port #(.NPINS(N)) dut (.*);

  // {dir,port,pud,pu_en,pu_val,dir_en,dir_val,out_en,out_val,die_en,die_val, oe,out,pu}
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    14'b01000000000_011, // plain input with pull-up
    14'b01100000000_010, // global disable
    14'b11000000000_110, // plain output
    14'b10011100000_001, // test-port input pin, pull-up forced on
    14'b00010111100_110, // test data-out while shifting
    14'b00010101100_010, // test data-out idle, tri-stated
    14'b11000100000_011, // receiver forces input, pull-up from port bit
    14'b10000100000_000, // receiver, port bit 0
    14'b00000111000_100, // transmitter forces output
    14'b01000001000_001, // compare output but direction 0
    14'b10000001100_110, // compare output with direction 1
    14'b11010100000_010, // oscillator disconnect
    14'b01010111000_100  // memory strobe forced output
  };

  function automatic logic [2:0] model(logic [10:0] c);
    logic d, o, p;
    d = c[5] ? c[4] : c[10];
    o = c[3] ? c[2] : c[9];
    p = c[7] ? c[6] : (!d && c[9] && !c[8]);
    return {d, o, p};
  endfunction

  task automatic apply(logic [10:0] c);
    dir_reg     = {N{c[10]}};
    port_reg    = {N{c[9]}};
    pud_global  = c[8];
    ovr_pu_en   = {N{c[7]}};
    ovr_pu_val  = {N{c[6]}};
    ovr_dir_en  = {N{c[5]}};
    ovr_dir_val = {N{c[4]}};
    ovr_out_en  = {N{c[3]}};
    ovr_out_val = {N{c[2]}};
    ovr_die_en  = {N{c[1]}};
    ovr_die_val = {N{c[0]}};
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_pins(logic [2:0] e, string req);
    logic [3*N-1:0] act, exp;
    act = {pad_oe, pad_out, pad_pu};
    exp = {{N{e[2]}}, {N{e[1]}}, {N{e[0]}}};
    chk(act == exp, req, 32'(act), 32'(exp));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    apply(11'b0);
    pad_in = '1;
    repeat (3) @(negedge clk);
    chk(din_sync == '0, "R8 in reset", 32'(din_sync), 0);
    pad_in = '0;
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(din_sync == '0, "R8 after release", 32'(din_sync), 0);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][13:3]);
      #1;
      chk_pins(VEC[v][2:0], "R1/R2/R3/R4 vector");
    end

    for (int c = 0; c < 2048; c++) begin
      apply(11'(c));
      #1;
      chk_pins(model(11'(c)), "R1 R2 R3 R4 R5 sweep");
    end

    apply(11'b00000000000); pad_in = '0;
    @(negedge clk);
    pad_in = 8'hA5;
    @(negedge clk);
    chk(din_sync == '0, "R7 one edge", 32'(din_sync), 0);
    @(negedge clk);
    chk(din_sync == 8'hA5, "R7 two edges", 32'(din_sync), 32'hA5);
    apply(11'b00000000010); #1;
    chk(din_sync == '0, "R6 gated", 32'(din_sync), 0);
    apply(11'b00000000011); #1;
    chk(din_sync == 8'hA5, "R6 forced enable", 32'(din_sync), 32'hA5);
    apply(11'b01100000000); #1;
    chk(pad_pu == '0, "R5 pud", 32'(pad_pu), 0);
    apply(11'b01111000000); #1;
    chk(pad_pu == '1, "R3 overrides pud", 32'(pad_pu), 32'hFF);
    ovr_die_en = 8'h0F; ovr_die_val = 8'h00; #1;
    chk(din_sync == 8'hA0, "R6 per pin", 32'(din_sync), 32'hA0);
    @(negedge clk); rst_n = 0; #1;
    chk(din_sync == '0, "R8 async", 32'(din_sync), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule